// File: doc/BRIEF.md
# Leading-One Locator with Remainder

This block examines a 48-bit operand and reports where its highest set bit lies, counting positions from the most significant end starting at 1. The reported position is added to a second 48-bit operand. The block also returns a remainder word: the bits that follow the leading one, moved up so that they start at the top of the word, with zeros filled in below. A second mode counts the ones in the operand, adds the second operand to that count, and clears the remainder.

An operation starts with a one-cycle strobe that samples both operands and the mode. The result, the remainder and a one-cycle completion pulse appear at the next clock edge. Both output words keep their values until the next strobe, so a consumer may read them at any later time. The locate is done by a combinational priority encoder, so every operation takes the same single cycle.

Top module: `lead_one_unit`

## Requirements
- R1: After reset, `done` is 0 and `result` and `remainder` are both 0.
- R2: With `mode` = 0 (locate) and a nonzero `a_in`, `result` is `x_in` plus the position of the highest set bit. The position is 1 when bit 47 is set and grows by one for each zero above the leading one.
- R3: With `mode` = 0 and `a_in` = 0, the position counts as 0. `result` equals `x_in` and `remainder` is 0.
- R4: With `mode` = 0 and `a_in` = 1, the position is 48, which differs from the zero-input case.
- R5: With `mode` = 0, `remainder` equals `a_in` shifted left by the position, keeping the low 48 bits. This places the bits below the leading one at the top of the word, with zeros below them.
- R6: With `mode` = 1 (count), `result` is the number of ones in `a_in` plus `x_in`, and `remainder` becomes 0 whatever it held before.
- R7: The addition of `x_in` is unsigned and wraps modulo 2^48 in both modes.
- R8: `done` is 1 in the cycle that follows a clock edge at which `start` was 1, and is 0 after an edge at which `start` was 0. A single strobe gives a pulse of exactly one cycle.
- R9: `result` and `remainder` hold their values while `start` is 0. Changes to `a_in`, `x_in` and `mode` without a strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that samples the operands and the mode |
| mode | input | 1 | 0 = locate leading one, 1 = count ones |
| a_in | input | 48 | Word to be examined |
| x_in | input | 48 | Addend for the position or the count |
| result | output | 48 | Position or count plus the addend, modulo 2^48 |
| remainder | output | 48 | Bits after the leading one, left-justified; 0 in count mode |
| done | output | 1 | One-cycle completion pulse |

## Verification
The only internal state is the registered output words and the completion flag, so a wrong internal value shows at the ports in the very cycle after the strobe. An encoder that is off by one shows up at once in `result`, and also in `remainder` as a shift that is one place wrong. The cases that separate a correct encoder from a nearly correct one are a zero operand, an operand of 1, and an operand whose top bit is set. A hold fault, where outputs drift while `start` is low, shows one cycle after the unstrobed input change. A stale remainder left from an earlier locate shows at the first count-mode result.

// File: rtl/lead_one_pkg.sv
package lead_one_pkg;
    typedef enum logic {
        OP_LOCATE = 1'b0,
        OP_COUNT  = 1'b1
    } op_mode_e;
endpackage

// File: rtl/lead_one_encoder.sv
module lead_one_encoder #(
    parameter int WIDTH = 48,
    localparam int PW = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] word_i,
    output logic [PW-1:0]    pos_o
);
    logic [PW-1:0] stage [WIDTH+1];

    assign stage[0] = '0;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_scan
            localparam logic [PW-1:0] RANK = PW'(WIDTH - i);
            assign stage[i+1] = word_i[i] ? RANK : stage[i];
        end
    endgenerate

    assign pos_o = stage[WIDTH];
endmodule

// File: rtl/ones_counter.sv
module ones_counter #(
    parameter int WIDTH = 48,
    localparam int PW = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] word_i,
    output logic [PW-1:0]    count_o
);
    logic [PW-1:0] acc [WIDTH+1];

    assign acc[0] = '0;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_add
            assign acc[i+1] = acc[i] + PW'(word_i[i]);
        end
    endgenerate

    assign count_o = acc[WIDTH];
endmodule

// File: rtl/lead_one_unit.sv
module lead_one_unit #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] x_in,
    output logic [WIDTH-1:0] result,
    output logic [WIDTH-1:0] remainder,
    output logic             done
);
    import lead_one_pkg::*;

    localparam int PW = $clog2(WIDTH + 1);

    typedef struct packed {
        logic             done;
        logic [WIDTH-1:0] result;
        logic [WIDTH-1:0] rem;
    } unit_state_t;

    unit_state_t   st_d, st_q;
    logic [PW-1:0] lead_pos;
    logic [PW-1:0] ones_cnt;
    logic [WIDTH-1:0] shifted;
    op_mode_e      op;

    lead_one_encoder #(.WIDTH(WIDTH)) enc_i (
        .word_i (a_in),
        .pos_o  (lead_pos)
    );

    ones_counter #(.WIDTH(WIDTH)) cnt_i (
        .word_i  (a_in),
        .count_o (ones_cnt)
    );

    assign op      = op_mode_e'(mode);
    assign shifted = a_in << lead_pos;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.done = 1'b1;
            case (op)
                OP_LOCATE: begin
                    st_d.result = x_in + WIDTH'(lead_pos);
                    st_d.rem    = shifted;
                end
                default: begin
                    st_d.result = x_in + WIDTH'(ones_cnt);
                    st_d.rem    = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result    = st_q.result;
    assign remainder = st_q.rem;
    assign done      = st_q.done;
endmodule

// File: rtl/lead_one_unit_chk.sv
module lead_one_unit_chk #(
    parameter int WIDTH = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             mode,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] x_in,
    input logic [WIDTH-1:0] result,
    input logic [WIDTH-1:0] remainder,
    input logic             done
);
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);
    localparam logic [WIDTH-1:0] FULL_POS = WIDTH'(WIDTH);

    assert_done_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(remainder)));

    assert_count_clears_rem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode) |=> (remainder == '0));

    assert_zero_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mode && a_in == '0) |=> (result == $past(x_in) && remainder == '0));

    assert_lsb_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mode && a_in == ONE) |=> (result == $past(x_in) + FULL_POS && remainder == '0));

    assert_top_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mode && a_in[WIDTH-1]) |=> (result == $past(x_in) + ONE));
endmodule

bind lead_one_unit lead_one_unit_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .a_in      (a_in),
    .x_in      (x_in),
    .result    (result),
    .remainder (remainder),
    .done      (done)
);

// File: tb/lead_one_unit_tb_top.sv
module lead_one_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 48;
    localparam int NV = 10;

    typedef struct packed {
        logic         m;
        logic [W-1:0] a;
        logic [W-1:0] x;
        logic [W-1:0] res;
        logic [W-1:0] rem;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b0, 48'h8000_0000_0000, 48'h0,              48'd1,              48'h0},
        '{1'b0, 48'h4000_0000_0001, 48'd5,              48'd7,              48'h4},
        '{1'b0, 48'h0000_0000_0F53, 48'h100,            48'h125,            48'hEA60_0000_0000},
        '{1'b0, 48'h0,              48'h1234,           48'h1234,           48'h0},
        '{1'b0, 48'h1,              48'h0,              48'd48,             48'h0},
        '{1'b0, 48'h0000_0001_8000, 48'h0,              48'd32,             48'h8000_0000_0000},
        '{1'b1, 48'h0000_0000_B742, 48'h0,              48'd8,              48'h0},
        '{1'b1, 48'hFFFF_FFFF_FFFF, 48'd2,              48'd50,             48'h0},
        '{1'b0, 48'h8000_0000_0000, 48'hFFFF_FFFF_FFFF, 48'h0,              48'h0},
        '{1'b1, 48'h0000_0000_000F, 48'hFFFF_FFFF_FFFE, 48'd2,              48'h0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] x_in = '0;
    logic [W-1:0] result;
    logic [W-1:0] remainder;
    logic         done;

    int total = 0;
    int bad = 0;
    string tags [NV];

    always #(CLK_PERIOD/2) clk = ~clk;

    lead_one_unit #(.WIDTH(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (mode),
        .a_in      (a_in),
        .x_in      (x_in),
        .result    (result),
        .remainder (remainder),
        .done      (done)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic m, input logic [W-1:0] a, input logic [W-1:0] x);
        @(negedge clk);
        start = 1'b1;
        mode  = m;
        a_in  = a;
        x_in  = x;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tags = '{"R2", "R2_R5", "R2_R5", "R3", "R4", "R2_R5",
                 "R6", "R6", "R7", "R7"};

        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 done", W'(done), '0);
        check("R1 result", result, '0);
        check("R1 remainder", remainder, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i].m, VEC[i].a, VEC[i].x);
            check({tags[i], " done"}, W'(done), W'(1));
            check({tags[i], " result"}, result, VEC[i].res);
            check({tags[i], " remainder"}, remainder, VEC[i].rem);
            @(negedge clk);
            check("R8 pulse end", W'(done), '0);
        end

        // R9: unstrobed input changes leave outputs untouched
        strobe(1'b0, 48'h0000_0000_0F53, 48'h100);
        mode = 1'b1;
        a_in = 48'hFFFF_0000_FFFF;
        x_in = 48'h7;
        repeat (3) @(negedge clk);
        check("R9 result hold", result, 48'h125);
        check("R9 remainder hold", remainder, 48'hEA60_0000_0000);
        check("R9 done low", W'(done), '0);

        // R8: back-to-back strobes keep done high, each result updated
        @(negedge clk);
        start = 1'b1; mode = 1'b0; a_in = 48'h0000_0000_0001; x_in = 48'h0;
        @(negedge clk);
        check("R8 back-to-back first done", W'(done), W'(1));
        check("R4 back-to-back first result", result, 48'd48);
        mode = 1'b1; a_in = 48'h0000_0000_0003; x_in = 48'h10;
        @(negedge clk);
        start = 1'b0;
        check("R8 back-to-back second done", W'(done), W'(1));
        check("R6 back-to-back second result", result, 48'h12);
        @(negedge clk);
        check("R8 back-to-back end", W'(done), '0);

        // R6: count mode clears a nonzero remainder left by a locate
        strobe(1'b0, 48'h0000_0000_0003, 48'h0);
        check("R5 rem before clear", remainder, 48'h8000_0000_0000);
        strobe(1'b1, 48'h0000_0000_0003, 48'h0);
        check("R6 rem cleared", remainder, '0);
        check("R6 count", result, 48'd2);

        // R1: reset mid-run returns to initial state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset result", result, '0);
        check("R1 reset done", W'(done), '0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule